// File: doc/BRIEF.md
# Backup Mode Entry Controller

This block decides when the device drops into its low-power backup state. Once that decision is made, it orders the shutdown of the core power domain. Two sources can ask for entry, and both live in the fast core clock domain.

The first source is a software write whose regulator-off bit is set. The second is a processor sleep instruction (wait-for-interrupt or wait-for-event) issued while the deep-sleep flag is high. A wait-for-interrupt issued with the sleep-on-exit flag set is not acted on at once. It is held pending until the processor signals its return from the lowest-priority handler to thread level.

The request crosses into the slow clock domain as a toggle, so a single-cycle strobe is never lost. In the slow domain the block then walks a fixed sequence:
- it pulls the active-low core reset and raises the processor/peripheral stop, both in the same cycle;
- a fixed number of slow cycles later, it drops the core regulator enable.

Once started, the sequence cannot be undone. Only a wake, which resets both domains, brings the block back to idle.

Top module: `bme_backup_entry`

## Requirements
- R1: After reset of both domains the outputs are idle: `core_nrst`=1, `periph_stop`=0, `vreg_en`=1.
- R2: A one-cycle `cfg_wr` with `cfg_vroff`=1 requests backup entry; a write with `cfg_vroff`=0 leaves the outputs idle.
- R3: A one-cycle `cpu_wfe` with `cpu_sleepdeep`=1 requests entry whatever `cpu_sleep_on_exit` is; with `cpu_sleepdeep`=0 it has no effect.
- R4: A one-cycle `cpu_wfi` with `cpu_sleepdeep`=1 and `cpu_sleep_on_exit`=0 requests entry immediately.
- R5: A `cpu_wfi` with `cpu_sleepdeep`=1 and `cpu_sleep_on_exit`=1 only arms a pending request, which fires on a later `cpu_handler_exit` strobe. A `cpu_handler_exit` with nothing pending has no effect, and a `cpu_wfi` with `cpu_sleepdeep`=0 has no effect.
- R6: `core_nrst` falls and `periph_stop` rises on the same slow clock rising edge. That edge is edge number SYNC_STAGES+1, counting slow edges after the core clock edge that captured the request. The outputs stay idle on all earlier edges.
- R7: `vreg_en` falls HALT_CYCLES slow edges after `core_nrst` falls. Until then `vreg_en` stays 1 while the reset and stop are asserted.
- R8: Once the sequence has started, it holds its reset/stop/off state until `bkp_rst`. A core-domain reset or further requests do not cancel it or change it.
- R9: Asserting both resets (a wake) during or after the sequence returns all outputs to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Fast core clock |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| slow_clk | input | 1 | Slow always-on clock |
| bkp_rst | input | 1 | Synchronous active-high reset, slow domain (power-on or wake) |
| cfg_wr | input | 1 | One-cycle strobe of a control register write |
| cfg_vroff | input | 1 | Regulator-off bit of that write |
| cpu_wfi | input | 1 | One-cycle strobe: wait-for-interrupt executed |
| cpu_wfe | input | 1 | One-cycle strobe: wait-for-event executed |
| cpu_sleepdeep | input | 1 | Deep-sleep flag of the processor |
| cpu_sleep_on_exit | input | 1 | Sleep-on-exit flag of the processor |
| cpu_handler_exit | input | 1 | One-cycle strobe: return from the lowest-priority handler to thread level |
| core_nrst | output | 1 | Active-low core domain reset, registered in slow domain |
| periph_stop | output | 1 | Stop for processor and peripherals, registered in slow domain |
| vreg_en | output | 1 | Core regulator enable, registered in slow domain |

## Verification
The bench builds the block with SYNC_STAGES=2 and HALT_CYCLES=2. With those values the halt counter has to count past its first value before the regulator drops, which exercises its terminal compare rather than an immediate exit. A slow clock ten times slower than the core clock, with edges offset from the core edges, lets the edge-by-edge check pin the reset edge to exactly SYNC_STAGES+1. The stimulus table covers every qualifying and non-qualifying combination of sleep flags. Directed cases cover the deferred request, a core-domain reset after shutdown, and a wake in mid-halt.

// File: rtl/bme_pkg.sv
package bme_pkg;

    typedef enum logic [1:0] {
        SEQ_RUN  = 2'd0,
        SEQ_HALT = 2'd1,
        SEQ_OFF  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic core_nrst;
        logic periph_stop;
        logic vreg_en;
    } seq_out_t;

    localparam seq_out_t OUT_RUN  = '{core_nrst: 1'b1, periph_stop: 1'b0, vreg_en: 1'b1};
    localparam seq_out_t OUT_HALT = '{core_nrst: 1'b0, periph_stop: 1'b1, vreg_en: 1'b1};
    localparam seq_out_t OUT_OFF  = '{core_nrst: 1'b0, periph_stop: 1'b1, vreg_en: 1'b0};

    function automatic seq_out_t out_for(seq_state_e st);
        case (st)
            SEQ_HALT: out_for = OUT_HALT;
            SEQ_OFF:  out_for = OUT_OFF;
            default:  out_for = OUT_RUN;
        endcase
    endfunction

    typedef struct packed {
        logic wfi;
        logic wfe;
        logic deep;
        logic on_exit;
    } sleep_req_t;

    function automatic logic sleep_now(sleep_req_t s);
        sleep_now = (s.wfe & s.deep) | (s.wfi & s.deep & ~s.on_exit);
    endfunction

    function automatic logic sleep_later(sleep_req_t s);
        sleep_later = s.wfi & s.deep & s.on_exit;
    endfunction

endpackage

// File: rtl/bme_req_gen.sv
module bme_req_gen
    import bme_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic       cfg_vroff,
    input  sleep_req_t sleep,
    input  logic       handler_exit,
    output logic       req_tgl
);

    logic pending_q;
    logic sent_q;
    logic tgl_q;
    logic immediate;
    logic fire;

    assign immediate = (cfg_wr & cfg_vroff) | sleep_now(sleep);
    assign fire      = ~sent_q & (immediate | (pending_q & handler_exit));

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            sent_q    <= 1'b0;
            tgl_q     <= 1'b0;
        end else begin
            if (fire) begin
                tgl_q  <= ~tgl_q;
                sent_q <= 1'b1;
            end
            if (sleep_later(sleep) && !sent_q) begin
                pending_q <= 1'b1;
            end
        end
    end

    assign req_tgl = tgl_q;

endmodule

// File: rtl/bme_sync.sv
module bme_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic pulse
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q[0] <= tgl_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            last_q <= chain_q[STAGES-1];
        end
    end

    assign pulse = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/bme_seq.sv
module bme_seq
    import bme_pkg::*;
#(
    parameter int HALT_CYCLES = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output seq_out_t outs
);

    localparam int CNT_W = $clog2(HALT_CYCLES) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALT_CYCLES - 1);

    seq_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    seq_out_t         out_q;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        case (st_q)
            SEQ_RUN: begin
                if (start) begin
                    st_n  = SEQ_HALT;
                    cnt_n = '0;
                end
            end
            SEQ_HALT: begin
                if (cnt_q == CNT_LAST) begin
                    st_n = SEQ_OFF;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_RUN;
            cnt_q <= '0;
            out_q <= OUT_RUN;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            out_q <= out_for(st_n);
        end
    end

    assign outs = out_q;

endmodule

// File: rtl/bme_backup_entry.sv
module bme_backup_entry
    import bme_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HALT_CYCLES = 1
) (
    input  logic core_clk,
    input  logic core_rst,
    input  logic slow_clk,
    input  logic bkp_rst,
    input  logic cfg_wr,
    input  logic cfg_vroff,
    input  logic cpu_wfi,
    input  logic cpu_wfe,
    input  logic cpu_sleepdeep,
    input  logic cpu_sleep_on_exit,
    input  logic cpu_handler_exit,
    output logic core_nrst,
    output logic periph_stop,
    output logic vreg_en
);

    sleep_req_t sleep;
    logic       req_tgl;
    logic       start_pulse;
    seq_out_t   seq_outs;

    assign sleep = '{wfi: cpu_wfi, wfe: cpu_wfe, deep: cpu_sleepdeep, on_exit: cpu_sleep_on_exit};

    bme_req_gen u_req (
        .clk          (core_clk),
        .rst          (core_rst),
        .cfg_wr       (cfg_wr),
        .cfg_vroff    (cfg_vroff),
        .sleep        (sleep),
        .handler_exit (cpu_handler_exit),
        .req_tgl      (req_tgl)
    );

    bme_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (slow_clk),
        .rst    (bkp_rst),
        .tgl_in (req_tgl),
        .pulse  (start_pulse)
    );

    bme_seq #(.HALT_CYCLES(HALT_CYCLES)) u_seq (
        .clk   (slow_clk),
        .rst   (bkp_rst),
        .start (start_pulse),
        .outs  (seq_outs)
    );

    assign core_nrst   = seq_outs.core_nrst;
    assign periph_stop = seq_outs.periph_stop;
    assign vreg_en     = seq_outs.vreg_en;

endmodule

// File: rtl/bme_backup_entry_chk.sv
module bme_backup_entry_chk (
    input logic core_clk,
    input logic core_rst,
    input logic slow_clk,
    input logic bkp_rst,
    input logic req_tgl,
    input logic core_nrst,
    input logic periph_stop,
    input logic vreg_en
);

    logic       prev_tgl;
    logic [1:0] flips;

    always_ff @(posedge core_clk) begin
        if (core_rst) begin
            prev_tgl <= 1'b0;
            flips    <= '0;
        end else begin
            prev_tgl <= req_tgl;
            if (req_tgl != prev_tgl && flips != 2'd3) begin
                flips <= flips + 2'd1;
            end
        end
    end

    // R8: one crossing per core-domain lifetime
    p_one_crossing_r8: assert property (@(posedge core_clk) disable iff (core_rst)
        flips <= 2'd1);

    // R1: reset drives idle outputs
    p_idle_after_reset_r1: assert property (@(posedge slow_clk)
        bkp_rst |=> (core_nrst && !periph_stop && vreg_en));

    // R6: reset and stop start together, regulator still on
    p_reset_with_stop_r6: assert property (@(posedge slow_clk) disable iff (bkp_rst)
        $fell(core_nrst) |-> ($rose(periph_stop) && vreg_en));

    // R7: regulator off only with reset and stop held
    p_off_needs_halt_r7: assert property (@(posedge slow_clk) disable iff (bkp_rst)
        !vreg_en |-> (!core_nrst && periph_stop));

    // R7: regulator drops only after reset was already asserted
    p_off_after_reset_r7: assert property (@(posedge slow_clk) disable iff (bkp_rst)
        $fell(vreg_en) |-> $past(!core_nrst));

    // R8: no cancel of reset
    p_no_cancel_r8: assert property (@(posedge slow_clk) disable iff (bkp_rst)
        !core_nrst |=> !core_nrst);

    // R8: regulator stays off
    p_off_sticky_r8: assert property (@(posedge slow_clk) disable iff (bkp_rst)
        !vreg_en |=> !vreg_en);

endmodule

bind bme_backup_entry bme_backup_entry_chk u_chk (
    .core_clk    (core_clk),
    .core_rst    (core_rst),
    .slow_clk    (slow_clk),
    .bkp_rst     (bkp_rst),
    .req_tgl     (req_tgl),
    .core_nrst   (core_nrst),
    .periph_stop (periph_stop),
    .vreg_en     (vreg_en)
);

// File: tb/sim_bme_backup_entry.sv
`timescale 1ns/1ps
module sim_bme_backup_entry;

    localparam int SYNC = 2;
    localparam int HALT = 2;
    localparam logic [2:0] IDLE  = 3'b101;  // {core_nrst, periph_stop, vreg_en}
    localparam logic [2:0] HALTD = 3'b011;
    localparam logic [2:0] OFF   = 3'b010;
    localparam int NV = 10;
    // {wr, vroff, wfi, wfe, deep, on_exit, handler_exit, expect_entry}
    localparam logic [7:0] VEC [NV] = '{
        8'b1100_0001,  // R2 write vroff=1
        8'b1000_0000,  // R2 write vroff=0
        8'b0001_1001,  // R3 wfe deep
        8'b0001_0000,  // R3 wfe no deep
        8'b0010_1001,  // R4 wfi deep sleep-now
        8'b0010_1100,  // R5 wfi on-exit, no exit
        8'b0010_1111,  // R5 wfi on-exit, exit
        8'b0010_0000,  // R5 wfi no deep
        8'b0001_1101,  // R3 wfe deep with on-exit set
        8'b0000_0010   // R5 exit alone
    };

    logic core_clk = 1'b0, slow_clk = 1'b0;
    logic core_rst = 1'b1, bkp_rst = 1'b1;
    logic cfg_wr = 0, cfg_vroff = 0, cpu_wfi = 0, cpu_wfe = 0;
    logic cpu_sleepdeep = 0, cpu_sleep_on_exit = 0, cpu_handler_exit = 0;
    logic core_nrst, periph_stop, vreg_en;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 core_clk = ~core_clk;
    initial begin
        #1;
        forever #20 slow_clk = ~slow_clk;
    end

    bme_backup_entry #(.SYNC_STAGES(SYNC), .HALT_CYCLES(HALT)) u0 (
        .core_clk(core_clk), .core_rst(core_rst), .slow_clk(slow_clk), .bkp_rst(bkp_rst),
        .cfg_wr(cfg_wr), .cfg_vroff(cfg_vroff), .cpu_wfi(cpu_wfi), .cpu_wfe(cpu_wfe),
        .cpu_sleepdeep(cpu_sleepdeep), .cpu_sleep_on_exit(cpu_sleep_on_exit),
        .cpu_handler_exit(cpu_handler_exit),
        .core_nrst(core_nrst), .periph_stop(periph_stop), .vreg_en(vreg_en)
    );

    task automatic check(string req, logic [2:0] exp);
        logic [2:0] got;
        got = {core_nrst, periph_stop, vreg_en};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic slow_edges(int n);
        for (int i = 0; i < n; i++) @(posedge slow_clk);
        #1;
    endtask

    task automatic wake();
        @(negedge core_clk);
        core_rst = 1; bkp_rst = 1;
        slow_edges(2);
        @(negedge core_clk);
        core_rst = 0; bkp_rst = 0;
    endtask

    // apply one-cycle strobe, return just after the capturing core edge
    task automatic strobe(logic wr, logic vroff, logic wfi, logic wfe, logic ex);
        @(negedge core_clk);
        cfg_wr = wr; cfg_vroff = vroff; cpu_wfi = wfi; cpu_wfe = wfe; cpu_handler_exit = ex;
        @(posedge core_clk);
        #1;
        cfg_wr = 0; cfg_vroff = 0; cpu_wfi = 0; cpu_wfe = 0; cpu_handler_exit = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wake();
        slow_edges(1);
        check("R1 reset state", IDLE);

        for (int i = 0; i < NV; i++) begin
            wake();
            cpu_sleepdeep     = VEC[i][3];
            cpu_sleep_on_exit = VEC[i][2];
            strobe(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], 1'b0);
            repeat (5) @(posedge core_clk);
            if (VEC[i][1]) strobe(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            slow_edges(SYNC + HALT + 3);
            check($sformatf("R2/R3/R4/R5 vector %0d", i), VEC[i][0] ? OFF : IDLE);
            cpu_sleepdeep = 0; cpu_sleep_on_exit = 0;
        end

        // R6/R7 edge-exact sequence
        wake();
        strobe(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int n = 1; n <= SYNC + HALT + 1; n++) begin
            slow_edges(1);
            if (n <= SYNC)             check($sformatf("R6 edge %0d", n), IDLE);
            else if (n <= SYNC + HALT) check($sformatf("R6/R7 edge %0d", n), HALTD);
            else                       check($sformatf("R7 edge %0d", n), OFF);
        end

        // R8: core reset and new request after shutdown
        @(negedge core_clk); core_rst = 1;
        repeat (4) @(posedge core_clk);
        @(negedge core_clk); core_rst = 0;
        cpu_sleepdeep = 1;
        strobe(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        cpu_sleepdeep = 0;
        slow_edges(SYNC + HALT + 3);
        check("R8 no cancel", OFF);

        // R9: wake mid-halt
        wake();
        strobe(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        slow_edges(SYNC + 1);
        check("R9 in halt before wake", HALTD);
        wake();
        slow_edges(1);
        check("R9 idle after wake", IDLE);

        // R5 deferred timing
        wake();
        cpu_sleepdeep = 1; cpu_sleep_on_exit = 1;
        strobe(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        slow_edges(5);
        check("R5 pending holds idle", IDLE);
        strobe(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        slow_edges(SYNC);
        check("R5 exit before sync", IDLE);
        slow_edges(1);
        check("R5 exit then halt", HALTD);
        cpu_sleepdeep = 0; cpu_sleep_on_exit = 0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule